// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block keeps a small set of one-bit ownership tokens that two independent requesters, a left port and a right port, use to agree on who holds a shared resource. Each port has a select and an address that name one token, and a write strobe with a single data bit. Writing 0 asks for the token. Writing 1 gives it back. The read output shows the selected token as 0 to the port that holds it and as 1 to any other port.

A request that arrives while the other side holds the token is not lost. It stays latched as pending. When the holder gives the token back, the token moves straight to the waiting side in that same clock edge, so the waiting port does not have to ask again. Each token is stored as one request latch per port plus a tie-break bit that records which side holds it when both latches are set.

The read path has no register: it shows the token state left by the most recent clock edge. A write takes effect at the rising edge where the strobe is sampled.

Top module: `sem_bank`

## Requirements
- R1: After reset every token is free, so both ports read 1 at every address.
- R2: A port that writes 0 to a free token holds it after that clock edge. It then reads 0 at that address, and the other port reads 1.
- R3: If the port that does not hold a token writes 0 to it, the token stays with its holder and the writer keeps reading 1. The request is kept as pending.
- R4: When the holder writes 1 and the other side has a pending request, the token goes to the other side at that edge. With no pending request the token becomes free, and both ports read 1.
- R5: A port that does not hold a token and writes 1 to it does not change which side holds it.
- R6: Writing 1 cancels the writer's own pending request. A later release by the holder then frees the token instead of handing it over.
- R7: If both ports write 0 to the same free token at the same edge, the left port gets the token and the right port's request is recorded as pending.
- R8: There are NUM_SEM tokens (8 by default), selected by the ADDR_W-bit address (3 bits by default). A write changes only the token at its address.
- R9: A port whose select is low makes no change to any token, even with its write strobe high. Its read output is then 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| l_sel | input | 1 | Left port select |
| l_we | input | 1 | Left port write strobe |
| l_addr | input | ADDR_W | Left port token address |
| l_wdata | input | 1 | Left port write bit (0 = request, 1 = release) |
| l_rdata | output | 1 | Left port read: 0 when the left side holds the addressed token |
| r_sel | input | 1 | Right port select |
| r_we | input | 1 | Right port write strobe |
| r_addr | input | ADDR_W | Right port token address |
| r_wdata | input | 1 | Right port write bit (0 = request, 1 = release) |
| r_rdata | output | 1 | Right port read: 0 when the right side holds the addressed token |

## Verification
Two of the block's functions can fall in the same cycle: a release by the holder and a request or cancel from the other side at the same address. The same goes for two requests that arrive together at a free token. These collisions are provoked on purpose: a left release together with a right request, and both ports writing 0 to a free token at once. A long random phase then packs both ports onto a small address range so that such overlaps happen often. A behavioural model in the bench tracks, for each token, who holds it and which side is pending. Its expected read value is compared with both read outputs on every clock.

// File: rtl/sem_pkg.sv
package sem_pkg;
  // Which side a token belongs to when both request latches are set.
  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;

  // One port's decoded action on one token in one cycle.
  typedef struct packed {
    logic req;   // write of 0
    logic rel;   // write of 1
  } sem_cmd_t;
endpackage

// File: rtl/sem_rst_sync.sv
module sem_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/sem_decode.sv
module sem_decode
  import sem_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
  input  logic                       sel,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wdata,
  output sem_cmd_t [NUM_SEM-1:0]     cmd
);
  logic wr_en;
  assign wr_en = sel & we;

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_dec
    logic hit;
    assign hit        = wr_en && (addr == ADDR_W'(i));
    assign cmd[i].req = hit & ~wdata;
    assign cmd[i].rel = hit &  wdata;
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  sem_cmd_t cmd_l,
  input  sem_cmd_t cmd_r,
  output logic     hold_l,
  output logic     hold_r
);
  logic  lreq_q, rreq_q, lreq_d, rreq_d;
  side_e own_q, own_d;
  logic  upd;

  assign hold_l = lreq_q & (~rreq_q | (own_q == SIDE_LEFT));
  assign hold_r = rreq_q & (~lreq_q | (own_q == SIDE_RIGHT));

  always_comb begin
    lreq_d = lreq_q;
    rreq_d = rreq_q;
    if (cmd_l.req) lreq_d = 1'b1;
    if (cmd_l.rel) lreq_d = 1'b0;
    if (cmd_r.req) rreq_d = 1'b1;
    if (cmd_r.rel) rreq_d = 1'b0;

    own_d = own_q;
    if (lreq_d && rreq_d) begin
      // Existing holder keeps it; a free token ties toward the left.
      own_d = hold_r ? SIDE_RIGHT : SIDE_LEFT;
    end else if (lreq_d) begin
      own_d = SIDE_LEFT;
    end else if (rreq_d) begin
      own_d = SIDE_RIGHT;
    end
  end

  assign upd = cmd_l.req | cmd_l.rel | cmd_r.req | cmd_r.rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lreq_q <= 1'b0;
      rreq_q <= 1'b0;
      own_q  <= SIDE_LEFT;
    end else if (upd) begin
      lreq_q <= lreq_d;
      rreq_q <= rreq_d;
      own_q  <= own_d;
    end
  end

  logic is_free;
  assign is_free = ~lreq_q & ~rreq_q;

  p_grant_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_free && cmd_l.req && !cmd_r.req) |=> (hold_l && !hold_r));

  p_keep_holder_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_l && cmd_r.req && !cmd_l.rel) |=> (hold_l && rreq_q));

  p_handoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_l && cmd_l.rel && rreq_q && !cmd_r.rel) |=> hold_r);

  p_release_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_r && cmd_r.rel && !lreq_q && !cmd_l.req) |=> (!hold_l && !hold_r));

  p_nonowner_rel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_l && cmd_r.rel && !cmd_l.rel) |=> hold_l);

  p_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_l && cmd_r.rel && !cmd_l.req) |=> !rreq_q);

  p_tie_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_free && cmd_l.req && cmd_r.req) |=> (hold_l && rreq_q));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cmd_l.req | cmd_l.rel | cmd_r.req | cmd_r.rel)) |=>
      ($stable(hold_l) && $stable(hold_r)));
endmodule

// File: rtl/sem_rdmux.sv
module sem_rdmux #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
  input  logic               sel,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SEM-1:0] hold,
  output logic               rdata
);
  always_comb begin
    rdata = 1'b1;
    for (int i = 0; i < NUM_SEM; i++) begin
      if (sel && (addr == ADDR_W'(i)) && hold[i]) rdata = 1'b0;
    end
  end
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wdata,
  output logic              l_rdata,
  input  logic              r_sel,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wdata,
  output logic              r_rdata
);
  logic                   rst_sync_n;
  sem_cmd_t [NUM_SEM-1:0] cmd_l, cmd_r;
  logic     [NUM_SEM-1:0] hold_l, hold_r;

  sem_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  sem_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) u_dec_l (
    .sel(l_sel), .we(l_we), .addr(l_addr), .wdata(l_wdata), .cmd(cmd_l));
  sem_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) u_dec_r (
    .sel(r_sel), .we(r_we), .addr(r_addr), .wdata(r_wdata), .cmd(cmd_r));

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
    sem_cell u_cell (
      .clk(clk), .rst_n(rst_sync_n),
      .cmd_l(cmd_l[i]), .cmd_r(cmd_r[i]),
      .hold_l(hold_l[i]), .hold_r(hold_r[i]));
  end

  sem_rdmux #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) u_rd_l (
    .sel(l_sel), .addr(l_addr), .hold(hold_l), .rdata(l_rdata));
  sem_rdmux #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) u_rd_r (
    .sel(r_sel), .addr(r_addr), .hold(hold_r), .rdata(r_rdata));

  p_one_holder_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hold_l & hold_r) == '0);

  p_addr_only_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(cmd_l) <= 1 && $countones(cmd_r) <= 1);

  p_unsel_quiet_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !l_sel |-> (cmd_l == '0 && l_rdata));
endmodule

// File: tb/sem_bank_bench.sv
`timescale 1ns/1ps
module sem_bank_bench;
  localparam int NUM_SEM = 8;
  localparam int ADDR_W  = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic l_sel, l_we, l_wdata, r_sel, r_we, r_wdata;
  logic [ADDR_W-1:0] l_addr, r_addr;
  logic l_rdata, r_rdata;

  int checks   = 0;
  int failures = 0;

  // Model: holder 0 = free, 1 = left, 2 = right; pending flags per side.
  int holder [NUM_SEM];
  bit pend_l [NUM_SEM];
  bit pend_r [NUM_SEM];

  always #2.5 clk = ~clk;

  sem_bank #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) u_sem_bank (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata));

  task automatic model_edge();
    for (int i = 0; i < NUM_SEM; i++) begin
      bit lq = l_sel && l_we && (int'(l_addr) == i) && !l_wdata;
      bit lr = l_sel && l_we && (int'(l_addr) == i) &&  l_wdata;
      bit rq = r_sel && r_we && (int'(r_addr) == i) && !r_wdata;
      bit rr = r_sel && r_we && (int'(r_addr) == i) &&  r_wdata;
      case (holder[i])
        0: begin
          if (lq) begin holder[i] = 1; pend_r[i] = rq; end
          else if (rq) holder[i] = 2;
        end
        1: begin
          if (lr) begin
            if (rq || (pend_r[i] && !rr)) holder[i] = 2; else holder[i] = 0;
            pend_r[i] = 0;
          end else begin
            if (rq) pend_r[i] = 1;
            if (rr) pend_r[i] = 0;
          end
        end
        default: begin
          if (rr) begin
            if (lq || (pend_l[i] && !lr)) holder[i] = 1; else holder[i] = 0;
            pend_l[i] = 0;
          end else begin
            if (lq) pend_l[i] = 1;
            if (lr) pend_l[i] = 0;
          end
        end
      endcase
    end
  endtask

  task automatic compare(string tag);
    logic exp_l, exp_r;
    exp_l = !(l_sel && holder[int'(l_addr)] == 1);
    exp_r = !(r_sel && holder[int'(r_addr)] == 2);
    checks++;
    if (l_rdata !== exp_l) begin
      failures++;
      $display("FAIL %s left read addr=%0d actual=%b expected=%b", tag, l_addr, l_rdata, exp_l);
    end
    checks++;
    if (r_rdata !== exp_r) begin
      failures++;
      $display("FAIL %s right read addr=%0d actual=%b expected=%b", tag, r_addr, r_rdata, exp_r);
    end
  endtask

  task automatic step(string tag,
                      bit ls, bit lw, int la, bit ld,
                      bit rs, bit rw, int ra, bit rd);
    @(negedge clk);
    model_edge();
    l_sel = ls; l_we = lw; l_addr = ADDR_W'(la); l_wdata = ld;
    r_sel = rs; r_we = rw; r_addr = ADDR_W'(ra); r_wdata = rd;
    #0.5;
    compare(tag);
  endtask

  task automatic rd(string tag, int la, int ra);
    step(tag, 1, 0, la, 0, 1, 0, ra, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NUM_SEM; i++) begin holder[i] = 0; pend_l[i] = 0; pend_r[i] = 0; end
    l_sel = 0; l_we = 0; l_addr = '0; l_wdata = 1;
    r_sel = 0; r_we = 0; r_addr = '0; r_wdata = 1;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: every token free after reset
    for (int a = 0; a < NUM_SEM; a++) rd("R1", a, NUM_SEM - 1 - a);

    // R2: left takes token 2
    step("R2", 1, 1, 2, 0, 0, 0, 0, 0);
    rd("R2", 2, 2);
    // R3: right asks while left holds
    step("R3", 0, 0, 0, 0, 1, 1, 2, 0);
    rd("R3", 2, 2);
    // R4: left releases, pending right takes over
    step("R4", 1, 1, 2, 1, 0, 0, 0, 0);
    rd("R4", 2, 2);
    // R4: right releases with nothing pending, token free
    step("R4", 0, 0, 0, 0, 1, 1, 2, 1);
    rd("R4", 2, 2);

    // R5: right writes 1 to a token the left holds
    step("R5", 1, 1, 4, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 1, 1, 4, 1);
    rd("R5", 4, 4);

    // R6: right request cancelled, then left release frees the token
    step("R6", 1, 1, 3, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 1, 1, 3, 0);
    step("R6", 0, 0, 0, 0, 1, 1, 3, 1);
    step("R6", 1, 1, 3, 1, 0, 0, 0, 0);
    rd("R6", 3, 3);

    // R7: simultaneous request on free token 5
    step("R7", 1, 1, 5, 0, 1, 1, 5, 0);
    rd("R7", 5, 5);
    // R4 with collision: left releases while right re-requests
    step("R4", 1, 1, 5, 1, 1, 1, 5, 0);
    rd("R4", 5, 5);
    step("R4", 0, 0, 0, 0, 1, 1, 5, 1);

    // R9: unselected writes ignored, unselected read shows 1
    step("R9", 0, 1, 6, 0, 0, 1, 6, 0);
    rd("R9", 6, 6);
    step("R9", 1, 1, 7, 0, 0, 1, 7, 0);
    step("R9", 0, 0, 7, 0, 1, 0, 7, 0);
    step("R9", 1, 1, 7, 1, 0, 0, 0, 0);

    // R8: random traffic over a narrow address range to force collisions
    for (int n = 0; n < 3000; n++) begin
      int span = (n < 1500) ? 2 : NUM_SEM;
      step("R8", bit'($urandom_range(0, 7) != 0), bit'($urandom_range(0, 1)),
           int'($urandom_range(0, span - 1)), bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 7) != 0), bit'($urandom_range(0, 1)),
           int'($urandom_range(0, span - 1)), bit'($urandom_range(0, 1)));
    end
    for (int a = 0; a < NUM_SEM; a++) rd("R8", a, a);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule